// File: doc/BRIEF.md
# Four-Channel High-Side Switch Configuration Register File

This block sits behind an SPI receiver that has already collected a complete 16-bit write word. Each word carries a register code, a two-bit extension field and a data payload. The block decodes the word and keeps the settings of a four-channel high-side switch controller. For each channel it holds an on/off enable, a current-sense mirror select, an over-current low-level code, an over-current high-level bit and a blanking-time code. All settings leave the block in parallel so the protection logic can read them without any handshake.

Two registers are shared by all four channels: the on/off enables and the sense-mirror selects. The threshold register and the blanking register are per channel. For these two, the extension field is a channel pointer, so a single write changes only the fields of the channel it names. The block also drives an output-enable for the current-sense pin. That enable is low whenever no channel is selected for mirroring, which leaves the pin free to share an A/D input with other devices. More than one mirror select may be set at once.

Top module: `sw_cfg_regfile`

## Requirements
- R1: A write word is split as follows: register code in bits 15:13, extension/channel field in bits 12:11, payload in bits 10:0. Only payload bits 3:0 carry settings.
- R2: A strobed word with code 001 and extension 00 loads the on/off enables. Payload bit i drives `ch_on[i]`, where 1 means on.
- R3: A strobed word with code 001 and extension 01 loads the sense-mirror selects. Payload bit i drives `sense_sel[i]`, and any mix of set bits is accepted.
- R4: `sense_oe` is 0 while all sense-mirror selects are 0, and 1 while at least one is set.
- R5: A strobed word with code 010 writes the thresholds of the channel named by bits 12:11. Payload bits 2:0 go to that channel's 3-bit low-level code, and payload bit 3 goes to its high-level bit. The other channels keep their values.
- R6: A strobed word with code 011 writes payload bits 1:0 into the 2-bit blanking code of the channel named by bits 12:11. The other channels keep their values.
- R7: Nothing changes in any of these cases: a word without the strobe, a code other than 001, 010 or 011, code 001 with extension 10 or 11, or payload bits above those named in R2–R6.
- R8: While `rst_n` is low, every enable, select and code is 0, so all channels are off and `sense_oe` is 0.
- R9: A strobed write shows on the outputs only after the rising clock edge that samples it, and it is visible throughout the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe marking a valid word |
| wr_word | input | 16 | Deframed SPI write word |
| ch_on | output | 4 | Per-channel on/off enables |
| sense_sel | output | 4 | Per-channel current-sense mirror selects |
| sense_oe | output | 1 | Sense-pin driver enable (0 = high impedance) |
| oc_low_code | output | 12 | Low-level codes, channel c in bits 3c+2:3c |
| oc_high_sel | output | 4 | High-level bit per channel |
| blank_code | output | 8 | Blanking codes, channel c in bits 2c+1:2c |

## Verification
The bench builds the block with its defaults: four channels, 3-bit low-level codes and 2-bit blanking codes. With these defaults the whole 5-bit space of register code and extension can be swept against all sixteen values of the payload nibble. Each step compares every channel's fields with an arithmetic model. This covers all channel pointers, every unlisted address, and every multi-channel sense pattern. Noise in the upper payload bits, writes without the strobe, the cycle just before a write edge, and a reset in mid-run each get a targeted check.

// File: rtl/sw_cfg_pkg.sv
package sw_cfg_pkg;

  localparam int WORD_W  = 16;
  localparam int CODE_LSB = 13;
  localparam int CODE_W  = 3;
  localparam int EXT_LSB = 11;
  localparam int EXT_W   = 2;
  localparam int PAY_W   = 4;   // payload bits that carry settings

  localparam logic [CODE_W-1:0] CODE_SHARED = 3'b001;
  localparam logic [CODE_W-1:0] CODE_THRESH = 3'b010;
  localparam logic [CODE_W-1:0] CODE_BLANK  = 3'b011;
  localparam logic [EXT_W-1:0]  EXT_ONOFF   = 2'b00;
  localparam logic [EXT_W-1:0]  EXT_SENSE   = 2'b01;

  typedef struct packed {
    logic              hit_onoff;
    logic              hit_sense;
    logic              hit_thresh;
    logic              hit_blank;
    logic [EXT_W-1:0]  ch;
    logic [PAY_W-1:0]  pay;
  } wr_cmd_t;

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[CODE_LSB +: CODE_W];
  endfunction

  function automatic logic [EXT_W-1:0] word_ext(input logic [WORD_W-1:0] w);
    return w[EXT_LSB +: EXT_W];
  endfunction

  function automatic wr_cmd_t decode_word(input logic vld, input logic [WORD_W-1:0] w);
    wr_cmd_t c;
    logic [CODE_W-1:0] code;
    logic [EXT_W-1:0]  ext;
    code = word_code(w);
    ext  = word_ext(w);
    c.hit_onoff  = vld && (code == CODE_SHARED) && (ext == EXT_ONOFF);
    c.hit_sense  = vld && (code == CODE_SHARED) && (ext == EXT_SENSE);
    c.hit_thresh = vld && (code == CODE_THRESH);
    c.hit_blank  = vld && (code == CODE_BLANK);
    c.ch         = ext;
    c.pay        = w[PAY_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/sw_cfg_decode.sv
module sw_cfg_decode
  import sw_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output wr_cmd_t           cmd,
  output logic              hit_any
);

  always_comb begin
    cmd     = decode_word(wr_en, wr_word);
    hit_any = cmd.hit_onoff | cmd.hit_sense | cmd.hit_thresh | cmd.hit_blank;
  end

  // R7: a word never reaches two register targets
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.hit_onoff, cmd.hit_sense, cmd.hit_thresh, cmd.hit_blank}));

  // R7: without the strobe nothing is targeted
  p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !hit_any);

endmodule

// File: rtl/sw_cfg_shared.sv
module sw_cfg_shared
  import sw_cfg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_cmd_t           cmd,
  output logic [NUM_CH-1:0] ch_on,
  output logic [NUM_CH-1:0] sense_sel,
  output logic              sense_oe
);

  logic [NUM_CH-1:0] on_q;
  logic [NUM_CH-1:0] sense_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= '0;
      sense_q <= '0;
    end else begin
      if (cmd.hit_onoff) on_q    <= cmd.pay[NUM_CH-1:0];
      if (cmd.hit_sense) sense_q <= cmd.pay[NUM_CH-1:0];
    end
  end

  always_comb begin
    ch_on     = on_q;
    sense_sel = sense_q;
    sense_oe  = |sense_q;
  end

  p_onoff_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.hit_onoff |=> ch_on == $past(cmd.pay[NUM_CH-1:0]));

  p_onoff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.hit_onoff |=> $stable(ch_on));

  p_sense_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.hit_sense |=> sense_sel == $past(cmd.pay[NUM_CH-1:0]));

  p_sense_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.hit_sense |=> $stable(sense_sel));

  p_tristate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit_sense && cmd.pay[NUM_CH-1:0] == '0) |=> !sense_oe);

  p_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit_sense && cmd.pay[NUM_CH-1:0] != '0) |=> sense_oe);

endmodule

// File: rtl/sw_cfg_chan.sv
module sw_cfg_chan
  import sw_cfg_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int LOW_W   = 3,
  parameter int BLANK_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wr_cmd_t            cmd,
  output logic [LOW_W-1:0]   low_code,
  output logic               high_sel,
  output logic [BLANK_W-1:0] blank_code
);

  localparam logic [EXT_W-1:0] MY_PTR = EXT_W'(IDX);

  logic               picked;
  logic               thresh_we;
  logic               blank_we;
  logic [LOW_W-1:0]   low_q;
  logic               high_q;
  logic [BLANK_W-1:0] blank_q;

  always_comb begin
    picked    = (cmd.ch == MY_PTR);
    thresh_we = cmd.hit_thresh && picked;
    blank_we  = cmd.hit_blank && picked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      high_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      if (thresh_we) begin
        low_q  <= cmd.pay[LOW_W-1:0];
        high_q <= cmd.pay[LOW_W];
      end
      if (blank_we) blank_q <= cmd.pay[BLANK_W-1:0];
    end
  end

  always_comb begin
    low_code   = low_q;
    high_sel   = high_q;
    blank_code = blank_q;
  end

  p_thresh_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit_thresh && cmd.ch == MY_PTR) |=>
      (low_code == $past(cmd.pay[LOW_W-1:0])) && (high_sel == $past(cmd.pay[LOW_W])));

  p_thresh_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.hit_thresh && cmd.ch == MY_PTR) |=> $stable(low_code) && $stable(high_sel));

  p_blank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hit_blank && cmd.ch == MY_PTR) |=> blank_code == $past(cmd.pay[BLANK_W-1:0]));

  p_blank_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.hit_blank && cmd.ch == MY_PTR) |=> $stable(blank_code));

endmodule

// File: rtl/sw_cfg_regfile.sv
module sw_cfg_regfile
  import sw_cfg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int LOW_W   = 3,
  parameter int BLANK_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [15:0]                wr_word,
  output logic [NUM_CH-1:0]          ch_on,
  output logic [NUM_CH-1:0]          sense_sel,
  output logic                       sense_oe,
  output logic [NUM_CH*LOW_W-1:0]    oc_low_code,
  output logic [NUM_CH-1:0]          oc_high_sel,
  output logic [NUM_CH*BLANK_W-1:0]  blank_code
);

  localparam int MAX_CH = 1 << EXT_W;

  initial begin
    if (NUM_CH > MAX_CH || NUM_CH > PAY_W || LOW_W + 1 > PAY_W || BLANK_W > PAY_W)
      $error("sw_cfg_regfile: parameters exceed the word layout");
  end

  wr_cmd_t cmd;
  logic    hit_any;

  sw_cfg_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .cmd     (cmd),
    .hit_any (hit_any)
  );

  sw_cfg_shared #(.NUM_CH(NUM_CH)) u_shared (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ch_on     (ch_on),
    .sense_sel (sense_sel),
    .sense_oe  (sense_oe)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sw_cfg_chan #(.IDX(c), .LOW_W(LOW_W), .BLANK_W(BLANK_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .low_code   (oc_low_code[c*LOW_W +: LOW_W]),
      .high_sel   (oc_high_sel[c]),
      .blank_code (blank_code[c*BLANK_W +: BLANK_W])
    );
  end

  // R7: a strobed word that hits no register leaves every output as it was
  p_unlisted_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_any) |=> $stable(ch_on) && $stable(sense_sel) &&
      $stable(oc_low_code) && $stable(oc_high_sel) && $stable(blank_code));

  // R8: reset leaves every setting cleared
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r8: assert (ch_on == '0 && sense_sel == '0 && !sense_oe &&
                                oc_low_code == '0 && oc_high_sel == '0 && blank_code == '0);
    end
  end

endmodule

// File: tb/sw_cfg_regfile_test.sv
module sw_cfg_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_word = '0;
  logic [3:0]  ch_on, sense_sel, oc_high_sel;
  logic        sense_oe;
  logic [11:0] oc_low_code;
  logic [7:0]  blank_code;

  int checks = 0;
  int failures = 0;

  logic [3:0]  m_on, m_sense, m_high;
  logic [11:0] m_low;
  logic [7:0]  m_blank;

  always #5 clk = ~clk;

  sw_cfg_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .ch_on(ch_on), .sense_sel(sense_sel), .sense_oe(sense_oe),
    .oc_low_code(oc_low_code), .oc_high_sel(oc_high_sel), .blank_code(blank_code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "ch_on", 32'(ch_on), 32'(m_on));
    chk(req, "sense_sel", 32'(sense_sel), 32'(m_sense));
    chk({req, "/R4"}, "sense_oe", 32'(sense_oe), 32'(m_sense != 4'h0));
    chk(req, "oc_low_code", 32'(oc_low_code), 32'(m_low));
    chk(req, "oc_high_sel", 32'(oc_high_sel), 32'(m_high));
    chk(req, "blank_code", 32'(blank_code), 32'(m_blank));
  endtask

  task automatic model_clear();
    m_on = '0; m_sense = '0; m_high = '0; m_low = '0; m_blank = '0;
  endtask

  // Model: 5-bit address view {code,ext}; 00100 on/off, 00101 sense (R1, R2, R3)
  task automatic model_write(input logic [15:0] w);
    int c;
    c = int'(w[12:11]);
    if (w[15:11] == 5'b00100) m_on = w[3:0];
    else if (w[15:11] == 5'b00101) m_sense = w[3:0];
    else if (w[15:13] == 3'b010) begin
      m_low[c*3 +: 3] = w[2:0];
      m_high[c] = w[3];
    end else if (w[15:13] == 3'b011) m_blank[c*2 +: 2] = w[1:0];
  endtask

  function automatic string req_of(input logic [4:0] a);
    if (a == 5'b00100) return "R1/R2";
    if (a == 5'b00101) return "R1/R3";
    if (a[4:2] == 3'b010) return "R1/R5";
    if (a[4:2] == 3'b011) return "R1/R6";
    return "R7";
  endfunction

  // Drive at a falling edge, let one rising edge sample, check at next falling edge
  task automatic do_write(input logic [15:0] w, input bit strobe, input string req, input bit pre_check);
    @(negedge clk);
    wr_word = w;
    wr_en = strobe;
    if (pre_check) begin
      #1;
      chk_all("R9");
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (strobe) model_write(w);
    chk_all(req);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk_all("R8");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R8");

    // Near-exhaustive sweep: all 32 code/extension pairs x all 16 payload nibbles,
    // upper payload bits filled with noise that must be ignored (R7)
    for (int a = 0; a < 32; a++) begin
      for (int d = 0; d < 16; d++) begin
        logic [15:0] w;
        w = {5'(a), 7'(a * 13 + d * 7 + 7'h55), 4'(d)};
        do_write(w, 1'b1, req_of(5'(a)), (d == 5));
      end
    end

    // Multi-channel sense patterns and the tri-state case (R3, R4)
    do_write(16'h2800 | 16'h000F, 1'b1, "R3", 1'b0);
    do_write(16'h2800 | 16'h0009, 1'b1, "R3", 1'b0);
    do_write(16'h2800, 1'b1, "R4", 1'b0);

    // Distinct per-channel values then isolation (R5, R6)
    for (int c = 0; c < 4; c++) begin
      do_write({3'b010, 2'(c), 7'h00, 4'(c + 9)}, 1'b1, "R5", 1'b0);
      do_write({3'b011, 2'(c), 7'h7F, 2'b00, 2'(3 - c)}, 1'b1, "R6", 1'b0);
    end

    // Strobe absent: valid targets must not change (R7)
    do_write({3'b001, 2'b00, 7'h00, 4'hA}, 1'b0, "R7", 1'b0);
    do_write({3'b010, 2'b10, 7'h00, 4'h6}, 1'b0, "R7", 1'b0);
    do_write({3'b001, 2'b11, 7'h00, 4'hF}, 1'b1, "R7", 1'b0);

    // Set everything non-zero, then reset mid-run (R8)
    do_write({3'b001, 2'b00, 7'h00, 4'hF}, 1'b1, "R2", 1'b1);
    do_write({3'b001, 2'b01, 7'h00, 4'h4}, 1'b1, "R3", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    chk_all("R8");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R8");
    do_write({3'b010, 2'b11, 7'h00, 4'hD}, 1'b1, "R5", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(1_000_000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule